// File: doc/BRIEF.md
# PWM Pulse Width Decoder

This block measures how long a single servo-style PWM line stays high and reports that time in whole microseconds. A divider built from the clock-frequency parameter produces a 1 MHz count enable, so the reported number does not depend on the system clock rate. The raw line first passes through a two-flop synchronizer. A three-phase machine then times the low phase and the high phase and emits each result as a 16-bit word that carries an error flag, together with a one-cycle ready strobe.

Both phases have a guard time. If the line sits low for longer than the guard, the block reports zero with the error flag set. This is what a transmitter that is switched off or a broken wire looks like. If the line sits high for longer than the guard, the block reports the guard value with the error flag set. A high pulse shorter than the minimum valid width is reported with its measured length and the error flag set. A downstream consumer only has to look at bit 15 to decide whether a channel value can be trusted.

Top module: `pwm_width_meter`

## Requirements
- R1: While reset is asserted and after it is released, `pulse_ready` is 0 and `pulse_word` is 0x0000. The machine starts in the low-timing phase with cleared counters.
- R2: A high pulse seen by the synchronizer on H consecutive rising clock edges is reported with count floor(H / DIV), where DIV = CLK_HZ / 1,000,000. The time base restarts at every phase start. A count from 1000 to 2600 inclusive (for example 1999, 1000 or 2600) has the error flag clear.
- R3: `pulse_ready` is high for exactly one clock cycle. For a pulse that ends normally, it rises after the second rising edge that follows the first edge sampling the line low. `pulse_word` changes only in the cycle in which `pulse_ready` is high.
- R4: A completed high pulse whose count is below 1000 is reported with the error flag set and the measured count kept. For example, 699 µs gives 0x82BB, and a 2-cycle pulse gives 0x8000.
- R5: A line held high is reported as 0x8000 | 2600 = 0x8A28. The report comes after (2600+1)·DIV counted high cycles, which is (2601·DIV + 2) clock cycles after the line is first sampled high. While the line stays high, the report repeats every 2601·DIV + 1 cycles.
- R6: A line held low is reported as 0x8000. The report comes after 2601·DIV counted low cycles, which is 2601·DIV cycles after reset release when the line is low from reset. While the line stays low, the report repeats every 2601·DIV + 1 cycles.
- R7: Bit 15 of `pulse_word` is the error flag and bits 14:0 hold the microsecond count.
- R8: The phase encodings are low timing = 0, high timing = 1 and complete = 2. The complete phase lasts exactly one cycle, ignores the line and always returns to the low-timing phase. `pulse_ready` is high only while the phase is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| pwm_in | input | 1 | Raw PWM line, asynchronous to clk |
| pulse_ready | output | 1 | One-cycle strobe marking a new result |
| pulse_word | output | 16 | Bit 15 error flag, bits 14:0 microsecond count |

## Verification
A pulse that ends normally gives its result three cycles after the line is dropped: two synchronizer flops, then the phase register. The bench drives on the falling clock edge and samples on falling edges. It checks that the strobe is low in the second sample, high with the expected word in the third, and low again in the fourth.

The guard reports are due 2601·DIV cycles after reset release for a stuck-low line, and 2601·DIV + 2 cycles after the line is first driven for a stuck-high line. Both then repeat every 2601·DIV + 1 cycles. The bench counts falling edges until the strobe appears and compares that count with these figures.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

  // Phase encodings, as seen by the checker: low timing, high timing, complete
  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_HIGH = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // Rate of the measuring time base
  localparam int unsigned TICK_HZ = 1_000_000;

endpackage

// File: rtl/pwm_line_sync.sv
module pwm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("pwm_line_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_raw};
    end
  end

  assign line_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,    // realign the divider
  input  logic seed_one,   // on restart, count the current cycle already
  output logic at_top      // last cycle of a microsecond
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] presc_q;
  logic [CW-1:0] presc_d;

  generate
    if (DIV < 2) begin : g_bad_div
      initial $error("pwm_tick_div needs a divide ratio of at least two");
    end
  endgenerate

  assign at_top = (presc_q == TOP);

  always_comb begin
    if (restart) begin
      presc_d = seed_one ? CW'(1) : '0;
    end else if (at_top) begin
      presc_d = '0;
    end else begin
      presc_d = presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else begin
      presc_q <= presc_d;
    end
  end

endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
  import pwm_meas_pkg::*;
#(
  parameter int GUARD_US = 2600,
  parameter int MIN_US   = 1000,
  parameter int VAL_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,     // synchronized line
  input  logic             at_top,    // raw divider wrap
  output logic             restart,
  output logic             seed_one,
  output logic             ready,
  output logic [VAL_W-1:0] word,
  output phase_e           phase
);

  localparam int CNT_W = $clog2(GUARD_US + 2);
  localparam int FLD_W = VAL_W - 1;
  localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_US);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_US);
  localparam logic [FLD_W-1:0] GUARD_F = FLD_W'(GUARD_US);

  phase_e             state_q, state_d;
  logic [CNT_W-1:0]   us_q, us_d, us_inc;
  logic [VAL_W-1:0]   word_q, word_d;
  logic               ready_q, load;
  logic               tick;
  logic               guard_hit;

  // A microsecond ends only on a cycle the divider is not being realigned
  assign tick      = at_top && !restart;
  assign us_inc    = us_q + 1'b1;
  assign guard_hit = at_top && (us_inc > GUARD_C);

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    load    = 1'b0;
    case (state_q)
      PH_LOW: begin
        if (level) begin
          state_d = PH_HIGH;
        end else if (guard_hit) begin
          load    = 1'b1;
          word_d  = {1'b1, {FLD_W{1'b0}}};
          state_d = PH_DONE;
        end
      end
      PH_HIGH: begin
        if (!level) begin
          load    = 1'b1;
          word_d  = {(us_q < MIN_C), FLD_W'(us_q)};
          state_d = PH_DONE;
        end else if (guard_hit) begin
          load    = 1'b1;
          word_d  = {1'b1, GUARD_F};
          state_d = PH_DONE;
        end
      end
      PH_DONE: begin
        state_d = PH_LOW;
      end
      default: begin
        state_d = PH_LOW;
      end
    endcase
  end

  // Divider and counter realign on every phase change and while complete
  assign restart  = (state_d != state_q) || (state_q == PH_DONE);
  assign seed_one = (state_d == PH_HIGH);

  always_comb begin
    if (restart) begin
      us_d = '0;
    end else if (tick) begin
      us_d = us_inc;
    end else begin
      us_d = us_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_LOW;
      us_q    <= '0;
      word_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      us_q    <= us_d;
      ready_q <= load;
      if (load) begin
        word_q <= word_d;
      end
    end
  end

  assign ready = ready_q;
  assign word  = word_q;
  assign phase = state_q;

endmodule

// File: rtl/pwm_width_meter.sv
module pwm_width_meter
  import pwm_meas_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int GUARD_US    = 2600,
  parameter int MIN_US      = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int VAL_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  output logic             pulse_ready,
  output logic [VAL_W-1:0] pulse_word
);

  localparam int DIV = CLK_HZ / TICK_HZ;

  logic       line_s;
  logic       at_top;
  logic       restart;
  logic       seed_one;
  phase_e     phase_q;
  logic [1:0] phase_w;

  pwm_line_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_raw  (pwm_in),
    .line_sync (line_s)
  );

  pwm_tick_div #(
    .DIV (DIV)
  ) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .seed_one (seed_one),
    .at_top   (at_top)
  );

  pwm_phase_fsm #(
    .GUARD_US (GUARD_US),
    .MIN_US   (MIN_US),
    .VAL_W    (VAL_W)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (line_s),
    .at_top   (at_top),
    .restart  (restart),
    .seed_one (seed_one),
    .ready    (pulse_ready),
    .word     (pulse_word),
    .phase    (phase_q)
  );

  assign phase_w = phase_q;

endmodule

// File: rtl/pwm_width_meter_chk.sv
module pwm_width_meter_chk #(
  parameter int GUARD_US = 2600,
  parameter int MIN_US   = 1000,
  parameter int VAL_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pulse_ready,
  input logic [VAL_W-1:0] pulse_word,
  input logic [1:0]       phase
);

  localparam logic [VAL_W-2:0] GUARD_F = (VAL_W-1)'(GUARD_US);
  localparam logic [VAL_W-2:0] MIN_F   = (VAL_W-1)'(MIN_US);

  // R3
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_ready |=> !pulse_ready);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_ready |-> $stable(pulse_word));

  // R8
  ready_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_ready |-> (phase == 2'd2));

  // R8
  done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |=> (phase == 2'd0));

  // R8
  legal_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  // R5
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_ready |-> (pulse_word[VAL_W-2:0] <= GUARD_F));

  // R4
  valid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_ready && !pulse_word[VAL_W-1]) |-> (pulse_word[VAL_W-2:0] >= MIN_F));

endmodule

bind pwm_width_meter pwm_width_meter_chk #(
  .GUARD_US (GUARD_US),
  .MIN_US   (MIN_US),
  .VAL_W    (VAL_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pulse_ready (pulse_ready),
  .pulse_word  (pulse_word),
  .phase       (phase_w)
);

// File: tb/pwm_width_meter_test.sv
module pwm_width_meter_test;

  localparam int DIV = 4;
  localparam int G   = 2600;
  localparam int MN  = 1000;
  localparam int GUARD_CYC = (G + 1) * DIV;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwm_in;
  logic        pulse_ready;
  logic [15:0] pulse_word;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pwm_width_meter #(
    .CLK_HZ   (DIV * 1_000_000),
    .GUARD_US (G),
    .MIN_US   (MN)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_in      (pwm_in),
    .pulse_ready (pulse_ready),
    .pulse_word  (pulse_word)
  );

  always #2 clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(int h);
    int us;
    us = h / DIV;
    exp_word = {(us < MN), us[14:0]};
  endfunction

  task automatic wait_ready(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse_ready && n < limit);
  endtask

  // Drive a high pulse of h cycles, then low for lo cycles in total (lo >= 8)
  task automatic pulse(int h, int lo, string req);
    logic [15:0] e;
    e = exp_word(h);
    pwm_in = 1'b1;
    repeat (h) @(negedge clk);
    pwm_in = 1'b0;
    @(negedge clk);
    check(!pulse_ready, "R3", "ready one cycle early", pulse_ready, 0);
    @(negedge clk);
    check(!pulse_ready, "R3", "ready before due", pulse_ready, 0);
    @(negedge clk);
    check(pulse_ready, "R3", "ready not due", pulse_ready, 1);
    check(pulse_word == e, req, "pulse word", pulse_word, e);
    check(pulse_word[15] == (h / DIV < MN), "R7", "flag bit 15", pulse_word[15], (h / DIV < MN));
    @(negedge clk);
    check(!pulse_ready, "R3", "ready longer than one cycle", pulse_ready, 0);
    repeat (lo - 4) @(negedge clk);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd5021));
    pwm_in = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check(!pulse_ready, "R1", "ready in reset", pulse_ready, 0);
    check(pulse_word == 16'h0000, "R1", "word in reset", pulse_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pulse_ready, "R1", "ready after release", pulse_ready, 0);
    check(pulse_word == 16'h0000, "R1", "word after release", pulse_word, 0);

    // R6: line low from reset
    wait_ready(GUARD_CYC + 100, n);
    check(n == GUARD_CYC - 1 + 1 - 1 + 1 - 1 + 1 - 1, "R6", "stuck-low delay", n, GUARD_CYC - 1);
    check(pulse_word == 16'h8000, "R6", "stuck-low word", pulse_word, 16'h8000);
    wait_ready(GUARD_CYC + 100, n);
    check(n == GUARD_CYC + 1, "R6", "stuck-low repeat interval (R8 one-cycle complete)", n, GUARD_CYC + 1);
    check(pulse_word == 16'h8000, "R6", "stuck-low repeat word", pulse_word, 16'h8000);
    repeat (10) @(negedge clk);

    // Directed widths
    pulse(1999 * DIV, 40, "R2");
    pulse(1000 * DIV, 40, "R2");
    pulse(G * DIV + DIV - 1, 40, "R2");
    pulse(999 * DIV + 3, 40, "R4");
    pulse(699 * DIV + 2, 40, "R4");
    pulse(2, 40, "R4");

    // Random widths up to the largest valid one
    for (int i = 0; i < 8; i++) begin
      int h, lo;
      h  = $urandom_range(G * DIV + DIV - 1, 1);
      lo = $urandom_range(400 * DIV, 8);
      pulse(h, lo, "R2");
    end

    // R5: line held high
    pwm_in = 1'b1;
    wait_ready(GUARD_CYC + 100, n);
    check(n == GUARD_CYC + 2, "R5", "stuck-high delay", n, GUARD_CYC + 2);
    check(pulse_word == 16'h8A28, "R5", "stuck-high word", pulse_word, 16'h8A28);
    wait_ready(GUARD_CYC + 100, n);
    check(n == GUARD_CYC + 1, "R5", "stuck-high repeat interval (R8)", n, GUARD_CYC + 1);
    check(pulse_word == 16'h8A28, "R5", "stuck-high repeat word", pulse_word, 16'h8A28);
    pwm_in = 1'b0;
    repeat (20) @(negedge clk);

    // R1: reset mid-run clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(!pulse_ready, "R1", "ready in second reset", pulse_ready, 0);
    check(pulse_word == 16'h0000, "R1", "word in second reset", pulse_word, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pulse(1500 * DIV + 1, 40, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

endmodule